// File: doc/BRIEF.md
# Serial Hold Pause Controller

This block sits between the pins of a serial slave port and its command engine and decides when the port is paused by an active-low hold input. A pause freezes the engine without clearing it: while it lasts, the clock-qualify enable is low, so the engine ignores serial clock and data activity. Its bit and byte counters therefore keep their values, and the transaction continues when the pause is released. During a pause the serial data output enable is also deasserted, which lets the pin float.

Entry and exit are qualified by the serial clock level. A change on the hold input that arrives while the serial clock is low takes effect at once. A change that arrives while the clock is high is deferred until the next falling clock edge. If chip select is released while the port is paused, the block ends the pause and sends a reset request, lasting a fixed number of cycles, to the command engine so that the half-finished transaction is dropped. All three pin inputs are assumed to be already synchronised to `clk`.

Top module: `hold_pause_ctrl`

## Requirements
- R1: After reset the port is not paused (`sck_en`=1, `abort_req`=0), even when `hold_n` is held low through reset. A pause needs a new falling edge of `hold_n` after reset.
- R2: A falling edge on `hold_n` while `cs_n`=0 and `sck`=0 pauses the port from the next cycle: `sck_en`=0 and `so_oe`=0.
- R3: A falling edge on `hold_n` while `sck`=1 does not pause the port at once. The pause begins in the cycle after the next falling edge of `sck`, provided `hold_n` is still low.
- R4: A rising edge on `hold_n` while paused with `sck`=0 ends the pause from the next cycle.
- R5: A rising edge on `hold_n` while paused with `sck`=1 keeps the port paused. The pause ends in the cycle after the next falling edge of `sck`.
- R6: A falling edge on `hold_n` while `cs_n`=1 has no effect: once the port is later selected, `sck_en` stays 1.
- R7: Raising `cs_n` while paused ends the pause and drives `abort_req`=1 for exactly ABORT_LEN cycles (default 2), starting in the next cycle.
- R8: Raising `cs_n` while not paused never asserts `abort_req`.
- R9: While paused with `hold_n` low and `cs_n` low, toggling `sck` does not end the pause.
- R10: A deferred entry is cancelled if `hold_n` returns high before the next `sck` falling edge. A deferred exit is cancelled if `hold_n` falls again before the next `sck` falling edge.
- R11: `so_oe` is 1 only while `cs_n`=0 and the port is not paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Synchronised chip select, active low |
| sck | input | 1 | Synchronised serial clock level |
| hold_n | input | 1 | Synchronised hold input, active low |
| sck_en | output | 1 | Clock-qualify enable to the command engine; 0 while paused |
| so_oe | output | 1 | Output enable for the serial data pin |
| abort_req | output | 1 | Transaction reset request to the command engine |

## Verification
The hold input is toggled in four situations: with the serial clock low, with it high, while deselected, and right after a reset during which it was low. Comparing the clock-low and clock-high cases separates immediate entry and exit from entry and exit deferred to the next falling clock edge. The deselected and post-reset cases show that only a qualified edge can start a pause. Further scenarios toggle the serial clock inside a pause, reverse the hold input while an entry or exit is deferred, and release chip select both while paused and while running, so that a correct abort pulse can be told apart from a spurious one.

// File: rtl/hold_pause_pkg.sv
// Package: shared types for the hold pause controller.
// Assumes: nothing beyond IEEE 1800-2017.
package hold_pause_pkg;

    // Pause state: running, entry deferred, paused, exit deferred.
    typedef enum logic [1:0] {
        HS_RUN        = 2'd0,
        HS_ENTER_WAIT = 2'd1,
        HS_PAUSED     = 2'd2,
        HS_EXIT_WAIT  = 2'd3
    } hold_state_t;

    // Indices of the pin samples kept by the history register.
    localparam int unsigned PIN_SCK  = 0;
    localparam int unsigned PIN_HOLD = 1;
    localparam int unsigned PIN_CNT  = 2;

    // True for the states in which the engine must be frozen.
    function automatic logic state_is_paused(input hold_state_t s);
        return (s == HS_PAUSED) || (s == HS_EXIT_WAIT);
    endfunction

endpackage

// File: rtl/hp_pin_history.sv
// Module: hp_pin_history
// Keeps a one-cycle-old copy of each synchronised pin so that edges can be found.
// Assumes: inputs are already synchronous to clk. Every stored bit resets to 0,
// so a pin that is low when reset is released never looks like a falling edge.
module hp_pin_history #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_now,
    output logic [WIDTH-1:0] pin_prev
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        // Store last cycle's level of one pin.
        always_ff @(posedge clk) begin
            if (!rst_n) pin_prev[g] <= 1'b0;
            else        pin_prev[g] <= pin_now[g];
        end
    end

endmodule

// File: rtl/hp_hold_fsm.sv
// Module: hp_hold_fsm
// Decides when a pause starts and ends, qualified by the serial clock level.
// A hold_n edge seen with sck low acts at once. One seen with sck high waits for
// the next sck falling edge. Deselecting always returns the FSM to running, and
// flags an abort when that happens during a pause.
// Assumes: the edge inputs come from the current and previous pin samples.
module hp_hold_fsm
    import hold_pause_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    input  logic hold_fall,
    input  logic hold_rise,
    input  logic sck_fall,
    output logic paused,
    output logic abort_evt
);

    hold_state_t state_q, state_d;

    // Next-state selection; deselect has priority over every hold event.
    always_comb begin
        state_d = state_q;
        if (cs_n) begin
            state_d = HS_RUN;
        end else begin
            unique case (state_q)
                HS_RUN: begin
                    if (hold_fall) state_d = sck ? HS_ENTER_WAIT : HS_PAUSED;
                end
                HS_ENTER_WAIT: begin
                    if (hold_n)        state_d = HS_RUN;
                    else if (sck_fall) state_d = HS_PAUSED;
                end
                HS_PAUSED: begin
                    if (hold_rise) state_d = sck ? HS_EXIT_WAIT : HS_RUN;
                end
                HS_EXIT_WAIT: begin
                    if (!hold_n)       state_d = HS_PAUSED;
                    else if (sck_fall) state_d = HS_RUN;
                end
                default: state_d = HS_RUN;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_RUN;
        else        state_q <= state_d;
    end

    assign paused    = state_is_paused(state_q);
    assign abort_evt = cs_n && state_is_paused(state_q);

    // R2: a qualified falling edge with sck low pauses at once.
    a_r2_enter_on_low_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_RUN && !cs_n && hold_fall && !sck) |=> paused);

    // R6: being deselected leaves the FSM running in the next cycle.
    a_r6_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !paused);

    // R9: with hold_n low and selected, a pause persists whatever sck does.
    a_r9_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !hold_n && !cs_n) |=> paused);

    // R3: a deferred entry does not pause before an sck falling edge.
    a_r3_defer_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_ENTER_WAIT && !cs_n && !sck_fall) |=> !paused);

endmodule

// File: rtl/hp_abort_stretch.sv
// Module: hp_abort_stretch
// Stretches a one-cycle abort event into a request of exactly LEN cycles.
// Assumes: LEN >= 1. A new trigger reloads the count.
module hp_abort_stretch #(
    parameter int unsigned LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy
);

    localparam int unsigned CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    // Load on trigger, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (trig)       cnt_q <= CW'(LEN);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R7: an abort event raises the request in the following cycle.
    a_r7_abort_follows: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> busy);

endmodule

// File: rtl/hold_pause_ctrl.sv
// Module: hold_pause_ctrl (top)
// Gates a serial slave port with an active-low hold input, qualified by sck.
// Produces the clock-qualify enable, the data output enable and an abort request.
// Assumes: cs_n, sck and hold_n are already synchronised to clk.
module hold_pause_ctrl
    import hold_pause_pkg::*;
#(
    parameter int unsigned ABORT_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic sck_en,
    output logic so_oe,
    output logic abort_req
);

    logic [PIN_CNT-1:0] pin_now, pin_prev;
    logic hold_fall, hold_rise, sck_fall;
    logic paused, abort_evt;

    assign pin_now[PIN_SCK]  = sck;
    assign pin_now[PIN_HOLD] = hold_n;

    hp_pin_history #(.WIDTH(PIN_CNT)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_now  (pin_now),
        .pin_prev (pin_prev)
    );

    // Edge strobes from the current and previous samples.
    assign hold_fall = pin_prev[PIN_HOLD] && !hold_n;
    assign hold_rise = !pin_prev[PIN_HOLD] && hold_n;
    assign sck_fall  = pin_prev[PIN_SCK] && !sck;

    hp_hold_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .hold_n    (hold_n),
        .hold_fall (hold_fall),
        .hold_rise (hold_rise),
        .sck_fall  (sck_fall),
        .paused    (paused),
        .abort_evt (abort_evt)
    );

    hp_abort_stretch #(.LEN(ABORT_LEN)) u_abort (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (abort_evt),
        .busy  (abort_req)
    );

    assign sck_en = !paused;
    assign so_oe  = !cs_n && !paused;

    // R11: the data pin is driven only while selected and running.
    a_r11_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (!cs_n && sck_en));

    // R8: a deselect from the running state raises no request.
    a_r8_no_spurious_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && sck_en && !abort_req) |=> !abort_req);

endmodule

// File: tb/hold_pause_ctrl_tb_top.sv
// Directed bench for hold_pause_ctrl: one task for each scenario.
module hold_pause_ctrl_tb_top;

    localparam int unsigned ABORT_LEN = 2;

    logic clk = 1'b0;
    logic rst_n;
    logic cs_n, sck, hold_n;
    logic sck_en, so_oe, abort_req;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    hold_pause_ctrl #(.ABORT_LEN(ABORT_LEN)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .hold_n    (hold_n),
        .sck_en    (sck_en),
        .so_oe     (so_oe),
        .abort_req (abort_req)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input logic got, input logic exp, input string what);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    task automatic do_reset(input logic hold_lvl);
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; hold_n = hold_lvl;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    // Select, clock low, hold high, settled.
    task automatic go_running();
        cs_n = 1'b0; sck = 1'b0; hold_n = 1'b1;
        step(2);
    endtask

    task automatic t_reset_state();
        do_reset(1'b0);
        check(sck_en, 1'b1, "R1 sck_en after reset");
        check(abort_req, 1'b0, "R1 abort_req after reset");
        cs_n = 1'b0; step(3);
        check(sck_en, 1'b1, "R1 low hold_n through reset gives no pause");
        hold_n = 1'b1; step(1); hold_n = 1'b0; step(1);
        check(sck_en, 1'b0, "R1 new falling edge pauses");
    endtask

    task automatic t_enter_low();
        do_reset(1'b1); go_running();
        check(so_oe, 1'b1, "R11 so_oe while running");
        hold_n = 1'b0; step(1);
        check(sck_en, 1'b0, "R2 sck_en paused");
        check(so_oe, 1'b0, "R2 so_oe paused");
    endtask

    task automatic t_enter_high();
        do_reset(1'b1); go_running();
        sck = 1'b1; step(1);
        hold_n = 1'b0; step(2);
        check(sck_en, 1'b1, "R3 no pause while sck high");
        sck = 1'b0; step(1);
        check(sck_en, 1'b0, "R3 pause after sck fall");
    endtask

    task automatic t_exit_low();
        do_reset(1'b1); go_running();
        hold_n = 1'b0; step(2);
        hold_n = 1'b1; step(1);
        check(sck_en, 1'b1, "R4 released");
        check(so_oe, 1'b1, "R4 so_oe restored");
    endtask

    task automatic t_exit_high();
        do_reset(1'b1); go_running();
        hold_n = 1'b0; step(2);
        sck = 1'b1; step(1);
        hold_n = 1'b1; step(2);
        check(sck_en, 1'b0, "R5 still paused with sck high");
        sck = 1'b0; step(1);
        check(sck_en, 1'b1, "R5 released after sck fall");
    endtask

    task automatic t_deselected();
        do_reset(1'b1);
        cs_n = 1'b1; sck = 1'b0; step(1);
        hold_n = 1'b0; step(1);
        cs_n = 1'b0; step(2);
        check(sck_en, 1'b1, "R6 edge while deselected ignored");
        check(so_oe, 1'b0 ^ 1'b1, "R6 so_oe while selected and running");
        cs_n = 1'b1; step(1);
        check(so_oe, 1'b0, "R11 so_oe low when deselected");
    endtask

    task automatic t_abort();
        do_reset(1'b1); go_running();
        hold_n = 1'b0; step(2);
        cs_n = 1'b1; step(1);
        check(abort_req, 1'b1, "R7 abort first cycle");
        check(sck_en, 1'b1, "R7 pause ended");
        step(ABORT_LEN - 1);
        check(abort_req, 1'b1, "R7 abort last cycle");
        step(1);
        check(abort_req, 1'b0, "R7 abort length");
    endtask

    task automatic t_no_abort();
        do_reset(1'b1); go_running();
        cs_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(1);
            check(abort_req, 1'b0, "R8 no abort from running");
        end
    endtask

    task automatic t_sck_in_pause();
        do_reset(1'b1); go_running();
        hold_n = 1'b0; step(1);
        for (int i = 0; i < 4; i++) begin
            sck = ~sck; step(1);
            check(sck_en, 1'b0, "R9 pause survives sck toggles");
        end
    endtask

    task automatic t_cancel();
        do_reset(1'b1); go_running();
        sck = 1'b1; step(1);
        hold_n = 1'b0; step(1);
        hold_n = 1'b1; step(1);
        sck = 1'b0; step(1);
        check(sck_en, 1'b1, "R10 deferred entry cancelled");
        hold_n = 1'b0; step(2);
        sck = 1'b1; step(1);
        hold_n = 1'b1; step(1);
        hold_n = 1'b0; step(1);
        sck = 1'b0; step(1);
        check(sck_en, 1'b0, "R10 deferred exit cancelled");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        step(20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; hold_n = 1'b1;
        step(1);
        t_reset_state();
        t_enter_low();
        t_enter_high();
        t_exit_low();
        t_exit_high();
        t_deselected();
        t_abort();
        t_no_abort();
        t_sck_in_pause();
        t_cancel();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule